// File: doc/BRIEF.md
# ISA Slave Front End for a Display Controller

This block connects a display controller to a 16-bit ISA expansion bus as a slave. It watches the host I/O and memory strobes and checks each address against three windows: a small I/O register window, a display-memory window and a ROM window. A qualified I/O cycle becomes a one-cycle access on an internal register port. A qualified memory cycle becomes a request on an internal display-memory port. The block maps the ISA byte lanes onto internal byte enables, moving odd bytes between lanes when the host makes an 8-bit transfer. While the memory port is busy it pulls the channel-ready line low. It holds read data on the host bus until the host releases its strobe.

The two 16-bit capability outputs come straight from address decode, so they are valid before any strobe arrives. While the address-enable input marks a DMA cycle, the block ignores I/O entirely. Memory strobes are honoured only in the lowest megabyte. The ROM enable output lets an external ROM drive reads in its own window.

Top module: `hostbus_isa_slave`

## Requirements
- R1: After reset is released, chan_rdy is 1, and mem_req, data_oe, reg_wr and reg_rd are 0.
- R2: While aen is 1, the block starts no I/O access: reg_wr and reg_rd stay 0 and io16_n stays 1, even for addresses inside the I/O window.
- R3: io16_n is 0 exactly when aen is 0 and addr[15:IO_WIN_LOG2] equals the same bits of IO_BASE. This depends on address decode alone, with no strobe needed.
- R4: mem16_n is 0 exactly when addr[21:20] is 0 and addr[19:MEM_WIN_LOG2] equals the same bits of MEM_BASE.
- R5: A memory strobe whose address is outside the lowest megabyte, or outside the display-memory window, raises no mem_req and leaves chan_rdy at 1.
- R6: A qualified I/O strobe produces one pulse on reg_wr (write) or reg_rd (read), in the first clock cycle the strobe is seen, with reg_addr = addr[IO_WIN_LOG2-1:0]. Both strobes low counts as a read.
- R7: Byte lanes follow {addr[0], sbhe_n}:
  - 00 gives enables 11 and data unchanged.
  - 01 gives enables 01.
  - 10 gives enables 10.
  - 11 gives enables 10 with the odd byte carried on bus bits [7:0]. Write data becomes {d[7:0], d[7:0]} and read data becomes {w[15:8], w[15:8]}.
- R8: A qualified memory strobe drops chan_rdy in the same cycle. mem_req rises at the next edge and holds stable address, enables, write flag and data until mem_ack. chan_rdy goes back to 1 at the edge that takes the acknowledge. The number of low cycles sampled after the first edge is the acknowledge latency plus one.
- R9: data_oe is 1 only once read data is latched and the read strobe of that cycle is still low. data_out then holds that data, and data_oe falls in the same cycle the strobe rises.
- R10: rom_oe_n is 0 exactly when memr_n is 0 and addr[21:ROM_WIN_LOG2] equals ROM_BASE[21:ROM_WIN_LOG2].
- R11: A strobe held low for many cycles causes only one access. A new access starts only after all four strobes have been high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| aen | input | 1 | DMA cycle flag, high during DMA |
| sbhe_n | input | 1 | Byte-high enable, active low |
| iow_n | input | 1 | I/O write strobe, active low |
| ior_n | input | 1 | I/O read strobe, active low |
| memw_n | input | 1 | Memory write strobe, active low |
| memr_n | input | 1 | Memory read strobe, active low |
| addr | input | 22 | Host address |
| data_in | input | 16 | Host write data |
| data_out | output | 16 | Host read data |
| data_oe | output | 1 | Drive enable for data_out |
| chan_rdy | output | 1 | Channel ready, low inserts waits |
| mem16_n | output | 1 | 16-bit memory capability, active low |
| io16_n | output | 1 | 16-bit I/O capability, active low |
| rom_oe_n | output | 1 | External ROM read enable, active low |
| reg_wr | output | 1 | Register write pulse |
| reg_rd | output | 1 | Register read pulse |
| reg_addr | output | IO_WIN_LOG2 | Register offset |
| reg_be | output | 2 | Register byte enables |
| reg_wdata | output | 16 | Register write data |
| reg_rdata | input | 16 | Register read data, combinational |
| mem_req | output | 1 | Display-memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | MEM_WIN_LOG2-1 | Word offset in the memory window |
| mem_be | output | 2 | Memory byte enables |
| mem_wdata | output | 16 | Memory write data |
| mem_ack | input | 1 | Memory port acknowledge |
| mem_rdata | input | 16 | Memory read data, valid with mem_ack |

## Verification
The bench uses the default parameters: a 16-port I/O window at 0x3C0, a 128 KB memory window at 0xA0000 and a 32 KB ROM window at 0xC0000. These windows are small enough to sweep their decode completely. The I/O sweep walks every port from 0x380 to 0x3FF with aen at both values. The memory sweep walks all 1024 values of the 4 KB page bits across the 22-bit space. The ROM sweep walks all 128 ROM-sized slots. Every bus cycle is run with each of the four byte-lane patterns, and memory cycles are also run against acknowledge latencies of 0 to 3 cycles. This makes the exact wait-state count and the odd-byte lane move observable.

// File: rtl/isa_slave_pkg.sv
package isa_slave_pkg;

  localparam int HOST_DW = 16;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_MWAIT = 2'd1,
    ST_HOLD  = 2'd2
  } cyc_state_t;

  typedef struct packed {
    logic [1:0] be;
    logic       swap;
  } lane_t;

  // Odd byte on an 8-bit transfer travels on the low bus lane.
  function automatic lane_t lane_decode(input logic a0, input logic sbhe_n);
    lane_t l;
    l.be   = {a0 | ~sbhe_n, ~a0};
    l.swap = a0 & sbhe_n;
    return l;
  endfunction

  function automatic logic [HOST_DW-1:0] bus_to_int(input logic [HOST_DW-1:0] d,
                                                    input logic swap);
    return swap ? {d[7:0], d[7:0]} : d;
  endfunction

  function automatic logic [HOST_DW-1:0] int_to_bus(input logic [HOST_DW-1:0] w,
                                                    input logic swap);
    return swap ? {w[15:8], w[15:8]} : w;
  endfunction

endpackage

// File: rtl/isa_rst_sync.sv
module isa_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/isa_addr_decode.sv
module isa_addr_decode
  import isa_slave_pkg::*;
#(
  parameter logic [15:0] IO_BASE      = 16'h03C0,
  parameter int          IO_WIN_LOG2  = 4,
  parameter logic [19:0] MEM_BASE     = 20'hA0000,
  parameter int          MEM_WIN_LOG2 = 17,
  parameter logic [21:0] ROM_BASE     = 22'h0C0000,
  parameter int          ROM_WIN_LOG2 = 15
) (
  input  logic [21:0] addr,
  input  logic        aen,
  input  logic        sbhe_n,
  output logic        io_hit,
  output logic        mem_hit,
  output logic        rom_hit,
  output lane_t       lane
);
  localparam int IO_TAG_W  = 16 - IO_WIN_LOG2;
  localparam int MEM_TAG_W = 20 - MEM_WIN_LOG2;
  localparam int ROM_TAG_W = 22 - ROM_WIN_LOG2;

  logic [IO_TAG_W-1:0]  io_tag;
  logic [MEM_TAG_W-1:0] mem_tag;
  logic [ROM_TAG_W-1:0] rom_tag;
  logic                 low_mb;

  always_comb begin
    io_tag  = addr[15:IO_WIN_LOG2];
    mem_tag = addr[19:MEM_WIN_LOG2];
    rom_tag = addr[21:ROM_WIN_LOG2];
    low_mb  = (addr[21:20] == 2'b00);
    io_hit  = ~aen && (io_tag == IO_BASE[15:IO_WIN_LOG2]);
    mem_hit = low_mb && (mem_tag == MEM_BASE[19:MEM_WIN_LOG2]);
    rom_hit = (rom_tag == ROM_BASE[21:ROM_WIN_LOG2]);
    lane    = lane_decode(addr[0], sbhe_n);
  end
endmodule

// File: rtl/isa_cycle_ctl.sv
module isa_cycle_ctl
  import isa_slave_pkg::*;
#(
  parameter int IO_WIN_LOG2  = 4,
  parameter int MEM_WIN_LOG2 = 17
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    io_hit,
  input  logic                    mem_hit,
  input  lane_t                   lane,
  input  logic                    ior_n,
  input  logic                    iow_n,
  input  logic                    memr_n,
  input  logic                    memw_n,
  input  logic [IO_WIN_LOG2-1:0]  io_off,
  input  logic [MEM_WIN_LOG2-1:1] mem_off,
  input  logic [HOST_DW-1:0]      data_in,
  output logic [HOST_DW-1:0]      data_out,
  output logic                    data_oe,
  output logic                    chan_rdy,
  output logic                    reg_wr,
  output logic                    reg_rd,
  output logic [IO_WIN_LOG2-1:0]  reg_addr,
  output logic [1:0]              reg_be,
  output logic [HOST_DW-1:0]      reg_wdata,
  input  logic [HOST_DW-1:0]      reg_rdata,
  output logic                    mem_req,
  output logic                    mem_we,
  output logic [MEM_WIN_LOG2-1:1] mem_addr,
  output logic [1:0]              mem_be,
  output logic [HOST_DW-1:0]      mem_wdata,
  input  logic                    mem_ack,
  input  logic [HOST_DW-1:0]      mem_rdata
);
  cyc_state_t state_q, state_d;
  logic       is_rd_q, is_rd_d;
  logic       is_io_q, is_io_d;
  logic       swap_q;
  logic       idle, io_go, mem_go, any_strobe, cmd_en, rd_en;
  logic [MEM_WIN_LOG2-1:1] maddr_q;
  logic [1:0]              mbe_q;
  logic [HOST_DW-1:0]      mwd_q, rd_q, rd_d;
  logic                    mwe_q;

  // Next-state and strobe qualification
  always_comb begin
    idle       = (state_q == ST_IDLE);
    any_strobe = ~(ior_n & iow_n & memr_n & memw_n);
    io_go      = idle && io_hit && (~ior_n || ~iow_n);
    mem_go     = idle && !io_go && mem_hit && (~memr_n || ~memw_n);
    cmd_en     = io_go || mem_go;
    state_d    = state_q;
    is_rd_d    = is_rd_q;
    is_io_d    = is_io_q;
    unique case (state_q)
      ST_IDLE: begin
        if (io_go) begin
          state_d = ST_HOLD;
          is_rd_d = ~ior_n;
          is_io_d = 1'b1;
        end else if (mem_go) begin
          state_d = ST_MWAIT;
          is_rd_d = ~memr_n;
          is_io_d = 1'b0;
        end
      end
      ST_MWAIT: if (mem_ack) state_d = ST_HOLD;
      ST_HOLD:  if (!any_strobe) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
    rd_en = (io_go && ~ior_n) || ((state_q == ST_MWAIT) && mem_ack && is_rd_q);
    rd_d  = io_go ? int_to_bus(reg_rdata, lane.swap) : int_to_bus(mem_rdata, swap_q);
  end

  // Control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      is_rd_q <= 1'b0;
      is_io_q <= 1'b0;
    end else begin
      state_q <= state_d;
      is_rd_q <= is_rd_d;
      is_io_q <= is_io_d;
    end
  end

  // Command capture, enabled at cycle start
  always_ff @(posedge clk) begin
    if (cmd_en) begin
      swap_q  <= lane.swap;
      maddr_q <= mem_off;
      mbe_q   <= lane.be;
      mwd_q   <= bus_to_int(data_in, lane.swap);
      mwe_q   <= memr_n;
    end
  end

  // Read data hold, enabled on data arrival
  always_ff @(posedge clk) begin
    if (rd_en) rd_q <= rd_d;
  end

  assign reg_rd    = io_go && ~ior_n;
  assign reg_wr    = io_go && ior_n;
  assign reg_addr  = io_off;
  assign reg_be    = lane.be;
  assign reg_wdata = bus_to_int(data_in, lane.swap);

  assign mem_req   = (state_q == ST_MWAIT);
  assign mem_we    = mwe_q;
  assign mem_addr  = maddr_q;
  assign mem_be    = mbe_q;
  assign mem_wdata = mwd_q;

  assign chan_rdy  = ~(mem_go || (state_q == ST_MWAIT));
  assign data_out  = rd_q;
  assign data_oe   = (state_q == ST_HOLD) && is_rd_q && (is_io_q ? ~ior_n : ~memr_n);
endmodule

// File: rtl/hostbus_isa_slave.sv
module hostbus_isa_slave
  import isa_slave_pkg::*;
#(
  parameter logic [15:0] IO_BASE      = 16'h03C0,
  parameter int          IO_WIN_LOG2  = 4,
  parameter logic [19:0] MEM_BASE     = 20'hA0000,
  parameter int          MEM_WIN_LOG2 = 17,
  parameter logic [21:0] ROM_BASE     = 22'h0C0000,
  parameter int          ROM_WIN_LOG2 = 15,
  parameter int          RST_STAGES   = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    aen,
  input  logic                    sbhe_n,
  input  logic                    iow_n,
  input  logic                    ior_n,
  input  logic                    memw_n,
  input  logic                    memr_n,
  input  logic [21:0]             addr,
  input  logic [15:0]             data_in,
  output logic [15:0]             data_out,
  output logic                    data_oe,
  output logic                    chan_rdy,
  output logic                    mem16_n,
  output logic                    io16_n,
  output logic                    rom_oe_n,
  output logic                    reg_wr,
  output logic                    reg_rd,
  output logic [IO_WIN_LOG2-1:0]  reg_addr,
  output logic [1:0]              reg_be,
  output logic [15:0]             reg_wdata,
  input  logic [15:0]             reg_rdata,
  output logic                    mem_req,
  output logic                    mem_we,
  output logic [MEM_WIN_LOG2-2:0] mem_addr,
  output logic [1:0]              mem_be,
  output logic [15:0]             mem_wdata,
  input  logic                    mem_ack,
  input  logic [15:0]             mem_rdata
);
  logic  rst_n_int, io_hit, mem_hit, rom_hit;
  lane_t lane;

  isa_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_int)
  );

  isa_addr_decode #(
    .IO_BASE(IO_BASE), .IO_WIN_LOG2(IO_WIN_LOG2),
    .MEM_BASE(MEM_BASE), .MEM_WIN_LOG2(MEM_WIN_LOG2),
    .ROM_BASE(ROM_BASE), .ROM_WIN_LOG2(ROM_WIN_LOG2)
  ) u_dec (
    .addr(addr), .aen(aen), .sbhe_n(sbhe_n),
    .io_hit(io_hit), .mem_hit(mem_hit), .rom_hit(rom_hit), .lane(lane)
  );

  isa_cycle_ctl #(.IO_WIN_LOG2(IO_WIN_LOG2), .MEM_WIN_LOG2(MEM_WIN_LOG2)) u_ctl (
    .clk(clk), .rst_n(rst_n_int),
    .io_hit(io_hit), .mem_hit(mem_hit), .lane(lane),
    .ior_n(ior_n), .iow_n(iow_n), .memr_n(memr_n), .memw_n(memw_n),
    .io_off(addr[IO_WIN_LOG2-1:0]), .mem_off(addr[MEM_WIN_LOG2-1:1]),
    .data_in(data_in), .data_out(data_out), .data_oe(data_oe), .chan_rdy(chan_rdy),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_be(reg_be),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  // 16-bit capability flags come from decode only, ahead of the strobes
  assign io16_n   = ~io_hit;
  assign mem16_n  = ~mem_hit;
  assign rom_oe_n = ~(rom_hit && ~memr_n);
endmodule

// File: rtl/isa_slave_chk.sv
module isa_slave_chk #(
  parameter int MEM_WIN_LOG2 = 17
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    aen,
  input logic                    ior_n,
  input logic                    iow_n,
  input logic                    memr_n,
  input logic                    memw_n,
  input logic [21:0]             addr,
  input logic                    data_oe,
  input logic                    chan_rdy,
  input logic                    io16_n,
  input logic                    reg_wr,
  input logic                    reg_rd,
  input logic                    mem_req,
  input logic                    mem_ack,
  input logic [MEM_WIN_LOG2-2:0] mem_addr,
  input logic [15:0]             mem_wdata
);
  assert_dma_blocks_io_R2: assert property (@(posedge clk) disable iff (!rst_n)
    aen |-> (!reg_wr && !reg_rd && io16_n));

  assert_one_reg_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_rd));

  assert_req_until_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> mem_req);

  assert_wait_while_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !chan_rdy);

  assert_req_payload_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> ($stable(mem_addr) && $stable(mem_wdata)));

  assert_req_low_mb_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req) |-> ($past(addr[21:20]) == 2'b00 && !($past(memr_n) && $past(memw_n))));

  assert_oe_needs_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    data_oe |-> (!ior_n || !memr_n));

  assert_no_reentry_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr || reg_rd) |=> !(reg_wr || reg_rd));
endmodule

bind hostbus_isa_slave isa_slave_chk #(.MEM_WIN_LOG2(MEM_WIN_LOG2)) u_chk (.*);

// File: tb/sim_hostbus_isa_slave.sv
module sim_hostbus_isa_slave;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic aen = 1'b0, sbhe_n = 1'b1, iow_n = 1'b1, ior_n = 1'b1, memw_n = 1'b1, memr_n = 1'b1;
  logic [21:0] addr = '0;
  logic [15:0] data_in = '0;
  logic [15:0] data_out, reg_wdata, reg_rdata, mem_wdata, mem_rdata;
  logic data_oe, chan_rdy, mem16_n, io16_n, rom_oe_n, reg_wr, reg_rd, mem_req, mem_we;
  logic [3:0]  reg_addr;
  logic [1:0]  reg_be, mem_be;
  logic [15:0] mem_addr;
  logic mem_ack = 1'b0;
  int   lat_cfg = 0;
  int   ack_cnt = 0;
  int   n_chk = 0, n_fail = 0;
  int   cyc = 0;

  always #5 clk = ~clk;

  hostbus_isa_slave u0 (.*);

  assign reg_rdata = 16'hC3A0 ^ {reg_addr, reg_addr, reg_addr, reg_addr};
  assign mem_rdata = mem_addr ^ 16'h5A3C;

  always @(negedge clk) begin
    mem_ack <= 1'b0;
    if (mem_req && !mem_ack) begin
      if (ack_cnt == lat_cfg) begin mem_ack <= 1'b1; ack_cnt <= 0; end
      else ack_cnt <= ack_cnt + 1;
    end else if (!mem_req) ack_cnt <= 0;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] x_be(input logic a0, input logic sb_n);
    return {a0 | ~sb_n, ~a0};
  endfunction
  function automatic logic [15:0] x_wd(input logic a0, input logic sb_n, input logic [15:0] d);
    return (a0 & sb_n) ? {d[7:0], d[7:0]} : d;
  endfunction
  function automatic logic [15:0] x_rd(input logic a0, input logic sb_n, input logic [15:0] w);
    return (a0 & sb_n) ? {w[15:8], w[15:8]} : w;
  endfunction

  // I/O cycle with expected register strobe and read-back
  task automatic io_cycle(input logic wr, input logic [21:0] a, input logic sb_n,
                          input logic dma, input logic [15:0] d);
    logic hit;
    logic [15:0] w;
    int extra;
    hit = (a[15:4] == 12'h03C) && !dma;
    w   = 16'hC3A0 ^ {a[3:0], a[3:0], a[3:0], a[3:0]};
    @(negedge clk);
    addr = a; sbhe_n = sb_n; aen = dma; data_in = d;
    if (wr) iow_n = 1'b0; else ior_n = 1'b0;
    #1;
    if (wr) chk(reg_wr == hit, "R6 write pulse", 32'(reg_wr), 32'(hit));
    else    chk(reg_rd == hit, "R6 read pulse", 32'(reg_rd), 32'(hit));
    if (dma) chk(!reg_wr && !reg_rd && io16_n, "R2 dma ignore", {reg_wr, reg_rd, io16_n}, 32'b001);
    if (hit) begin
      chk(reg_addr == a[3:0], "R6 reg_addr", 32'(reg_addr), 32'(a[3:0]));
      chk(reg_be == x_be(a[0], sb_n), "R7 reg_be", 32'(reg_be), 32'(x_be(a[0], sb_n)));
      if (wr) chk(reg_wdata == x_wd(a[0], sb_n, d), "R7 reg_wdata", 32'(reg_wdata), 32'(x_wd(a[0], sb_n, d)));
      chk(chan_rdy == 1'b1, "R8 io no wait", 32'(chan_rdy), 32'd1);
    end
    extra = 0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); #1;
      if (reg_wr || reg_rd) extra++;
      if (!wr && hit && k == 0) begin
        chk(data_oe == 1'b1, "R9 io oe", 32'(data_oe), 32'd1);
        chk(data_out == x_rd(a[0], sb_n, w), "R9 R7 io rdata", 32'(data_out), 32'(x_rd(a[0], sb_n, w)));
      end
      if (!hit) chk(data_oe == 1'b0, "R9 no oe on miss", 32'(data_oe), 32'd0);
    end
    chk(extra == 0, "R11 single io access", 32'(extra), 32'd0);
    @(negedge clk);
    iow_n = 1'b1; ior_n = 1'b1; #1;
    chk(data_oe == 1'b0, "R9 oe release", 32'(data_oe), 32'd0);
    @(negedge clk);
    aen = 1'b0;
  endtask

  // Memory cycle through the request/acknowledge port
  task automatic mem_cycle(input logic wr, input logic [21:0] a, input logic sb_n,
                           input logic [15:0] d, input int lat);
    int waits;
    logic [15:0] w;
    lat_cfg = lat;
    w = a[16:1] ^ 16'h5A3C;
    @(negedge clk);
    addr = a; sbhe_n = sb_n; data_in = d;
    if (wr) memw_n = 1'b0; else memr_n = 1'b0;
    #1;
    chk(chan_rdy == 1'b0, "R8 ready drops at strobe", 32'(chan_rdy), 32'd0);
    chk(mem_req == 1'b0, "R8 req not yet", 32'(mem_req), 32'd0);
    @(negedge clk); #1;
    chk(mem_req == 1'b1, "R8 req raised", 32'(mem_req), 32'd1);
    chk(mem_we == wr, "R8 mem_we", 32'(mem_we), 32'(wr));
    chk(mem_addr == a[16:1], "R8 mem_addr", 32'(mem_addr), 32'(a[16:1]));
    chk(mem_be == x_be(a[0], sb_n), "R7 mem_be", 32'(mem_be), 32'(x_be(a[0], sb_n)));
    if (wr) chk(mem_wdata == x_wd(a[0], sb_n, d), "R7 mem_wdata", 32'(mem_wdata), 32'(x_wd(a[0], sb_n, d)));
    waits = 0;
    for (int k = 0; k < 20 && chan_rdy == 1'b0; k++) begin
      waits++;
      @(negedge clk); #1;
    end
    chk(waits == lat + 1, "R8 wait count", 32'(waits), 32'(lat + 1));
    chk(mem_req == 1'b0, "R8 req dropped", 32'(mem_req), 32'd0);
    if (!wr) begin
      chk(data_oe == 1'b1, "R9 mem oe", 32'(data_oe), 32'd1);
      chk(data_out == x_rd(a[0], sb_n, w), "R9 R7 mem rdata", 32'(data_out), 32'(x_rd(a[0], sb_n, w)));
    end
    @(negedge clk); #1;
    chk(mem_req == 1'b0, "R11 no second request", 32'(mem_req), 32'd0);
    memw_n = 1'b1; memr_n = 1'b1; #1;
    chk(data_oe == 1'b0, "R9 oe release", 32'(data_oe), 32'd0);
    @(negedge clk);
  endtask

  task automatic mem_miss(input logic wr, input logic [21:0] a);
    @(negedge clk);
    addr = a;
    if (wr) memw_n = 1'b0; else memr_n = 1'b0;
    for (int k = 0; k < 3; k++) begin
      #1;
      chk(chan_rdy == 1'b1 && mem_req == 1'b0, "R5 miss ignored", {chan_rdy, mem_req}, 32'b10);
      @(negedge clk);
    end
    memw_n = 1'b1; memr_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    chk(chan_rdy == 1'b1, "R1 reset chan_rdy", 32'(chan_rdy), 32'd1);
    chk({mem_req, data_oe, reg_wr, reg_rd} == 4'b0, "R1 reset idle", {mem_req, data_oe, reg_wr, reg_rd}, 32'd0);

    // Decode sweeps, no strobes
    for (int p = 16'h0380; p < 16'h0400; p++) begin
      for (int e = 0; e < 2; e++) begin
        addr = 22'(p); aen = e[0]; #1;
        chk(io16_n == !((p[15:4] == 12'h03C) && e == 0), "R3 R2 io16_n sweep", 32'(io16_n), 32'(!((p[15:4] == 12'h03C) && e == 0)));
      end
    end
    aen = 1'b0;
    for (int i = 0; i < 1024; i++) begin
      addr = {i[9:0], 12'h123}; #1;
      chk(mem16_n == !(i[9:5] == 5'b00101), "R4 mem16_n sweep", 32'(mem16_n), 32'(!(i[9:5] == 5'b00101)));
    end
    for (int i = 0; i < 128; i++) begin
      addr = {i[6:0], 15'h0456};
      if (addr[21:17] != 5'b00101) begin
        memr_n = 1'b0; #1;
        chk(rom_oe_n == !(i == 8'h18), "R10 rom read", 32'(rom_oe_n), 32'(!(i == 8'h18)));
        memr_n = 1'b1; memw_n = 1'b0; #1;
        chk(rom_oe_n == 1'b1, "R10 rom write", 32'(rom_oe_n), 32'd1);
        memw_n = 1'b1;
      end
    end

    // I/O cycles over lanes, DMA flag and window hit/miss
    for (int l = 0; l < 4; l++) begin
      for (int e = 0; e < 2; e++) begin
        io_cycle(1'b1, 22'h0003C4 | 22'(l[1]), l[0], e[0], 16'h1234 + 16'(l * 16'h0101));
        io_cycle(1'b0, 22'h0003CA | 22'(l[1]), l[0], e[0], 16'h0);
      end
      io_cycle(1'b1, 22'h0003B6 | 22'(l[1]), l[0], 1'b0, 16'hBEEF);
    end

    // Memory cycles over lanes and latencies
    for (int lat = 0; lat < 4; lat++) begin
      for (int l = 0; l < 4; l++) begin
        mem_cycle(1'b1, 22'h0A1234 + 22'(lat * 22'h0400) + 22'(l[1]), l[0], 16'hA55A ^ 16'(lat), lat);
        mem_cycle(1'b0, 22'h0B8760 + 22'(lat * 22'h0402) + 22'(l[1]), l[0], 16'h0, lat);
      end
    end

    mem_miss(1'b1, 22'h1A1234);
    mem_miss(1'b0, 22'h2B0000);
    mem_miss(1'b0, 22'h0D1234);
    mem_miss(1'b1, 22'h090000);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule